// File: doc/BRIEF.md
# Cascaded Layer Alpha Compositor

This block builds one output pixel stream by stacking up to four ARGB layers on top of a flat background colour. The background is generated inside the block. It covers the whole output frame and is always fully opaque. Stage 0 blends layer 0 over that background. Each later stage blends its own layer over the result of the stage before it, so layer 3 lands on top.

Each layer has three settings: an enable, a flag that says whether its colour is already scaled by its alpha, and a top-left placement inside the output frame. A layer affects only the pixels inside its own window. Layers and output are valid/ready streams with one pixel per transfer. The block tracks the raster position of the output and of each layer itself.

Frames are started by holding `stream_en` high while the block is idle. At that moment every configuration input is copied, and the copy stays fixed until the frame has ended.

Top module: `alpha_blend_cascade`

## Requirements
- R1: Pixels are packed A[31:24], R[23:16], G[15:8], B[7:0]. For a straight-alpha layer, every colour channel becomes dst*(255-a)/255 + src*a/255. Each product is rounded as (x*y+127)/255.
- R2: For a premultiplied layer, the source colour is added without being scaled by its alpha: dst*(255-a)/255 + src. The sum saturates at 255.
- R3: Output alpha is dst_a*(255-a)/255 + a. The background alpha is forced to 0xFF, so every output pixel has alpha 0xFF.
- R4: Where no enabled layer covers a pixel, the output is {0xFF, cfg_bg_rgb}.
- R5: Layers are applied in index order, and the highest-numbered layer ends up on top.
- R6: A disabled layer passes its destination through unchanged. Its ready output stays 0, so its input stream is never consumed.
- R7: Frame width and height are clamped to 1..8190. Each frame emits exactly width*height pixels. `out_sof` is set on the first pixel of the frame, and `out_eol` is set on the last pixel of each row. No pixel appears outside a frame.
- R8: Layer offsets are clamped to at most width-1 (x) and height-1 (y). The layer window has the same size as the layer's input.
- R9: Layer pixels that fall right of or below the frame are consumed but never blended.
- R10: While `out_valid` is high and `out_ready` is low, the output pixel and its flags hold. No pixel is lost or repeated.
- R11: Configuration is sampled only at frame start. A change made during a frame first affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stream_en | input | 1 | Start a frame when the block is idle |
| cfg_bg_rgb | input | 24 | Background colour R,G,B |
| cfg_frame_w | input | DIMW | Output frame width |
| cfg_frame_h | input | DIMW | Output frame height |
| cfg_layer_en | input | NLAYERS | Per-layer enable |
| cfg_layer_premul | input | NLAYERS | Per-layer premultiplied flag |
| cfg_layer_x | input | NLAYERS*DIMW | Per-layer x offset |
| cfg_layer_y | input | NLAYERS*DIMW | Per-layer y offset |
| cfg_layer_w | input | NLAYERS*DIMW | Per-layer input width |
| cfg_layer_h | input | NLAYERS*DIMW | Per-layer input height |
| lyr_valid | input | NLAYERS | Layer pixel valid |
| lyr_ready | output | NLAYERS | Layer pixel accepted |
| lyr_data | input | NLAYERS*32 | Layer ARGB pixels |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output sink ready |
| out_data | output | 32 | Output ARGB pixel |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of row |

## Verification
Two things can happen in the same cycle. One layer can be discarding a clipped pixel while another layer's pixel is being blended into the output. The bench provokes this with two layers: one is pushed past the right edge of a 3x2 frame and the other past its bottom edge. It then checks every output position against the expected mix of background and layer pixels.

Output backpressure can also coincide with layers offering new pixels. The bench toggles `out_ready` over a window of distinct layer pixels and checks that each one arrives exactly once and in order.

// File: rtl/abl_pkg.sv
package abl_pkg;
    localparam int CH_W  = 8;
    localparam int PIX_W = 4 * CH_W;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} raster_state_e;

    // round(a*b/255), exact for 8-bit operands
    function automatic logic [7:0] mul_norm(input logic [7:0] a, input logic [7:0] b);
        logic [16:0] t;
        t = {9'd0, a} * {9'd0, b} + 17'd128;
        return 8'((t + (t >> 8)) >> 8);
    endfunction

    function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[8] ? 8'hFF : s[7:0];
    endfunction
endpackage

// File: rtl/abl_blend_stage.sv
module abl_blend_stage
    import abl_pkg::*;
(
    input  logic [PIX_W-1:0] dst_pix,
    input  logic [PIX_W-1:0] src_pix,
    input  logic             apply,
    input  logic             premul,
    output logic [PIX_W-1:0] res_pix
);
    logic [7:0] src_a;
    logic [7:0] inv_a;
    logic [PIX_W-1:0] mixed;

    assign src_a = src_pix[31:24];
    assign inv_a = 8'hFF - src_a;

    assign mixed[31:24] = sat_add(mul_norm(dst_pix[31:24], inv_a), src_a);

    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [7:0] term;
        assign term = premul ? src_pix[c*CH_W +: CH_W]
                             : mul_norm(src_pix[c*CH_W +: CH_W], src_a);
        assign mixed[c*CH_W +: CH_W] = sat_add(mul_norm(dst_pix[c*CH_W +: CH_W], inv_a), term);
    end

    assign res_pix = apply ? mixed : dst_pix;
endmodule

// File: rtl/abl_layer_tracker.sv
module abl_layer_tracker #(
    parameter int DIMW = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            active,
    input  logic            take,
    input  logic            en,
    input  logic [DIMW-1:0] org_x,
    input  logic [DIMW-1:0] org_y,
    input  logic [DIMW-1:0] size_x,
    input  logic [DIMW-1:0] size_y,
    input  logic [DIMW-1:0] frame_w,
    input  logic [DIMW-1:0] frame_h,
    input  logic [DIMW-1:0] pos_x,
    input  logic [DIMW-1:0] pos_y,
    input  logic            in_valid,
    output logic            in_ready,
    output logic            covers,
    output logic            ok,
    output logic            done
);
    localparam int EW = DIMW + 1;

    typedef struct packed {
        logic [DIMW-1:0] cnt_x;
        logic [DIMW-1:0] cnt_y;
    } trk_t;

    trk_t s_d, s_q;
    logic [EW-1:0] map_x, map_y;
    logic clipped, aligned;

    assign map_x   = EW'(org_x) + EW'(s_q.cnt_x);
    assign map_y   = EW'(org_y) + EW'(s_q.cnt_y);
    assign done    = !en || (s_q.cnt_y == size_y);
    assign clipped = !done && (map_x >= EW'(frame_w) || map_y >= EW'(frame_h));
    assign covers  = en && (pos_x >= org_x) && (EW'(pos_x) < EW'(org_x) + EW'(size_x))
                        && (pos_y >= org_y) && (EW'(pos_y) < EW'(org_y) + EW'(size_y));
    assign aligned = !done && (map_x == EW'(pos_x)) && (map_y == EW'(pos_y));
    assign ok       = !covers || (in_valid && aligned);
    assign in_ready = active && en && (clipped || (take && covers));

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.cnt_x = '0;
            s_d.cnt_y = '0;
        end else if (in_valid && in_ready) begin
            if (s_q.cnt_x == size_x - 1'b1) begin
                s_d.cnt_x = '0;
                s_d.cnt_y = s_q.cnt_y + 1'b1;
            end else begin
                s_d.cnt_x = s_q.cnt_x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: the layer walk never runs past its own window
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && en) |-> (s_q.cnt_y <= size_y && s_q.cnt_x < size_x));
endmodule

// File: rtl/alpha_blend_cascade.sv
module alpha_blend_cascade
    import abl_pkg::*;
#(
    parameter int NLAYERS = 4,
    parameter int DIMW    = 13,
    parameter int MAX_DIM = 8190
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stream_en,
    input  logic [23:0]               cfg_bg_rgb,
    input  logic [DIMW-1:0]           cfg_frame_w,
    input  logic [DIMW-1:0]           cfg_frame_h,
    input  logic [NLAYERS-1:0]        cfg_layer_en,
    input  logic [NLAYERS-1:0]        cfg_layer_premul,
    input  logic [NLAYERS*DIMW-1:0]   cfg_layer_x,
    input  logic [NLAYERS*DIMW-1:0]   cfg_layer_y,
    input  logic [NLAYERS*DIMW-1:0]   cfg_layer_w,
    input  logic [NLAYERS*DIMW-1:0]   cfg_layer_h,
    input  logic [NLAYERS-1:0]        lyr_valid,
    output logic [NLAYERS-1:0]        lyr_ready,
    input  logic [NLAYERS*PIX_W-1:0]  lyr_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [PIX_W-1:0]          out_data,
    output logic                      out_sof,
    output logic                      out_eol
);
    localparam logic [DIMW-1:0] DIM_ONE = DIMW'(1);
    localparam logic [DIMW-1:0] DIM_MAX = DIMW'(MAX_DIM);

    typedef struct packed {
        raster_state_e                   st;
        logic [DIMW-1:0]                 px;
        logic [DIMW-1:0]                 py;
        logic [DIMW-1:0]                 fw;
        logic [DIMW-1:0]                 fh;
        logic [23:0]                     bg;
        logic [NLAYERS-1:0]              en;
        logic [NLAYERS-1:0]              pm;
        logic [NLAYERS-1:0][DIMW-1:0]    ox;
        logic [NLAYERS-1:0][DIMW-1:0]    oy;
        logic [NLAYERS-1:0][DIMW-1:0]    lw;
        logic [NLAYERS-1:0][DIMW-1:0]    lh;
        logic                            ov;
        logic [PIX_W-1:0]                od;
        logic                            sof;
        logic                            eol;
    } blend_state_t;

    blend_state_t s_d, s_q;

    logic [NLAYERS:0][PIX_W-1:0] chain;
    logic [NLAYERS-1:0] lyr_cov, lyr_ok, lyr_done;
    logic active, start, fire, slot;
    logic [DIMW-1:0] fw_in, fh_in;

    function automatic logic [DIMW-1:0] clamp_size(input logic [DIMW-1:0] v);
        if (v == '0)     return DIM_ONE;
        if (v > DIM_MAX) return DIM_MAX;
        return v;
    endfunction

    function automatic logic [DIMW-1:0] clamp_off(input logic [DIMW-1:0] v, input logic [DIMW-1:0] lim);
        return (v > lim - DIM_ONE) ? lim - DIM_ONE : v;
    endfunction

    assign fw_in  = clamp_size(cfg_frame_w);
    assign fh_in  = clamp_size(cfg_frame_h);
    assign active = (s_q.st != ST_IDLE);
    assign start  = (s_q.st == ST_IDLE) && stream_en;
    assign slot   = !s_q.ov || out_ready;
    assign fire   = (s_q.st == ST_RUN) && (&lyr_ok) && slot;

    assign chain[0] = {8'hFF, s_q.bg};

    for (genvar k = 0; k < NLAYERS; k++) begin : g_layer
        abl_layer_tracker #(.DIMW(DIMW)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .active   (active),
            .take     (fire),
            .en       (s_q.en[k]),
            .org_x    (s_q.ox[k]),
            .org_y    (s_q.oy[k]),
            .size_x   (s_q.lw[k]),
            .size_y   (s_q.lh[k]),
            .frame_w  (s_q.fw),
            .frame_h  (s_q.fh),
            .pos_x    (s_q.px),
            .pos_y    (s_q.py),
            .in_valid (lyr_valid[k]),
            .in_ready (lyr_ready[k]),
            .covers   (lyr_cov[k]),
            .ok       (lyr_ok[k]),
            .done     (lyr_done[k])
        );

        abl_blend_stage u_stage (
            .dst_pix (chain[k]),
            .src_pix (lyr_data[k*PIX_W +: PIX_W]),
            .apply   (lyr_cov[k]),
            .premul  (s_q.pm[k]),
            .res_pix (chain[k+1])
        );

        // R6: a layer switched off for this frame never accepts input
        assert_off_layer_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.en[k] |-> !lyr_ready[k]);
    end

    always_comb begin
        s_d = s_q;
        if (s_q.ov && out_ready) s_d.ov = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (stream_en) begin
                    s_d.st = ST_RUN;
                    s_d.px = '0;
                    s_d.py = '0;
                    s_d.fw = fw_in;
                    s_d.fh = fh_in;
                    s_d.bg = cfg_bg_rgb;
                    s_d.en = cfg_layer_en;
                    s_d.pm = cfg_layer_premul;
                    for (int k = 0; k < NLAYERS; k++) begin
                        s_d.ox[k] = clamp_off(cfg_layer_x[k*DIMW +: DIMW], fw_in);
                        s_d.oy[k] = clamp_off(cfg_layer_y[k*DIMW +: DIMW], fh_in);
                        s_d.lw[k] = clamp_size(cfg_layer_w[k*DIMW +: DIMW]);
                        s_d.lh[k] = clamp_size(cfg_layer_h[k*DIMW +: DIMW]);
                    end
                end
            end
            ST_RUN: begin
                if (fire) begin
                    s_d.ov  = 1'b1;
                    s_d.od  = chain[NLAYERS];
                    s_d.sof = (s_q.px == '0) && (s_q.py == '0);
                    s_d.eol = (s_q.px == s_q.fw - DIM_ONE);
                    if (s_q.px == s_q.fw - DIM_ONE) begin
                        s_d.px = '0;
                        if (s_q.py == s_q.fh - DIM_ONE) begin
                            s_d.py = '0;
                            s_d.st = ST_DRAIN;
                        end else begin
                            s_d.py = s_q.py + DIM_ONE;
                        end
                    end else begin
                        s_d.px = s_q.px + DIM_ONE;
                    end
                end
            end
            ST_DRAIN: begin
                if (&lyr_done) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_sof   = s_q.sof;
    assign out_eol   = s_q.eol;

    // R3: the opaque background keeps every emitted pixel opaque
    assert_opaque_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[31:24] == 8'hFF));

    // R10: a stalled output holds its pixel and flags
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eol)));

    // R11: the configuration snapshot is frozen while a frame is in flight
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(s_q.fw) && $stable(s_q.fh) && $stable(s_q.bg)
                    && $stable(s_q.en) && $stable(s_q.pm)));
endmodule

// File: tb/alpha_blend_cascade_tb_top.sv
module alpha_blend_cascade_tb_top;
    localparam int NL = 4;
    localparam int DW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stream_en = 1'b0;
    logic [23:0] cfg_bg_rgb = '0;
    logic [DW-1:0] cfg_frame_w = 13'd1, cfg_frame_h = 13'd1;
    logic [NL-1:0] cfg_layer_en = '0, cfg_layer_premul = '0;
    logic [NL*DW-1:0] cfg_layer_x = '0, cfg_layer_y = '0, cfg_layer_w = '0, cfg_layer_h = '0;
    logic [NL-1:0] lyr_valid = '0;
    logic [NL-1:0] lyr_ready;
    logic [NL*32-1:0] lyr_data = '0;
    logic out_valid, out_ready = 1'b1, out_sof, out_eol;
    logic [31:0] out_data;

    always #5 clk = ~clk;

    alpha_blend_cascade dut_i (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .cfg_bg_rgb(cfg_bg_rgb),
        .cfg_frame_w(cfg_frame_w), .cfg_frame_h(cfg_frame_h),
        .cfg_layer_en(cfg_layer_en), .cfg_layer_premul(cfg_layer_premul),
        .cfg_layer_x(cfg_layer_x), .cfg_layer_y(cfg_layer_y),
        .cfg_layer_w(cfg_layer_w), .cfg_layer_h(cfg_layer_h),
        .lyr_valid(lyr_valid), .lyr_ready(lyr_ready), .lyr_data(lyr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    typedef struct packed {
        logic [23:0] bg;
        logic [31:0] src;
        logic        pm;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{24'h102030, 32'h80FF0040, 1'b0, 32'hFF881038},
        '{24'h102030, 32'h80FF0040, 1'b1, 32'hFFFF1058},
        '{24'h102030, 32'h00FF0040, 1'b0, 32'hFF102030},
        '{24'h102030, 32'hFF123456, 1'b0, 32'hFF123456},
        '{24'h102030, 32'h00050000, 1'b1, 32'hFF152030}
    };

    int n_chk = 0, n_err = 0;
    logic [31:0] lpix [NL][16];
    int lcnt [NL];
    logic [31:0] obuf [16];
    logic osof [16], oeol [16];
    int got, sof_cnt, eol_cnt, last_eol;
    logic [NL-1:0] dis_mask = '0;
    logic saw_dis;
    logic chg_en = 1'b0;
    logic [23:0] chg_val = '0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_layer(input int k, input logic en, input logic pm,
                             input int x, input int y, input int w, input int h);
        cfg_layer_en[k] = en;
        cfg_layer_premul[k] = pm;
        cfg_layer_x[k*DW +: DW] = DW'(x);
        cfg_layer_y[k*DW +: DW] = DW'(y);
        cfg_layer_w[k*DW +: DW] = DW'(w);
        cfg_layer_h[k*DW +: DW] = DW'(h);
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < NL; k++) begin
            set_layer(k, 1'b0, 1'b0, 0, 0, 1, 1);
            lcnt[k] = 0;
        end
    endtask

    task automatic drive_layer(input int k);
        logic hs;
        for (int i = 0; i < lcnt[k]; i++) begin
            lyr_valid[k] = 1'b1;
            lyr_data[k*32 +: 32] = lpix[k][i];
            do begin
                #4;
                hs = lyr_ready[k];
                @(negedge clk);
            end while (!hs);
        end
        lyr_valid[k] = 1'b0;
    endtask

    task automatic collect(input int n, input logic bp);
        int cyc;
        cyc = 0; got = 0; sof_cnt = 0; eol_cnt = 0; last_eol = -1; saw_dis = 1'b0;
        while (got < n) begin
            out_ready = bp ? (cyc % 3 == 0) : 1'b1;
            #4;
            if ((lyr_ready & dis_mask) != '0) saw_dis = 1'b1;
            if (out_valid && out_ready) begin
                if (got < 16) begin
                    obuf[got] = out_data; osof[got] = out_sof; oeol[got] = out_eol;
                end
                if (out_sof) sof_cnt++;
                if (out_eol) begin eol_cnt++; last_eol = got; end
                got++;
                if (chg_en && got == 1) cfg_bg_rgb = chg_val;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b1;
    endtask

    task automatic run_frame(input int n, input logic bp);
        @(negedge clk);
        stream_en = 1'b1;
        @(negedge clk);
        stream_en = 1'b0;
        fork
            drive_layer(0);
            drive_layer(1);
            drive_layer(2);
            drive_layer(3);
            collect(n, bp);
        join
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R7 act=running exp=finished");
        finish_run();
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R7 reset out_valid", 32'(out_valid), 0);
        chk(lyr_ready == '0, "R6 reset lyr_ready", 32'(lyr_ready), 0);

        // R1 R2 R3: blend arithmetic from the vector table
        for (int v = 0; v < 5; v++) begin
            clear_cfg();
            cfg_frame_w = 13'd1; cfg_frame_h = 13'd1;
            cfg_bg_rgb = VECS[v].bg;
            set_layer(0, 1'b1, VECS[v].pm, 0, 0, 1, 1);
            lpix[0][0] = VECS[v].src; lcnt[0] = 1;
            run_frame(1, 1'b0);
            chk(obuf[0] == VECS[v].exp, VECS[v].pm ? "R2 premul blend" : "R1 straight blend",
                obuf[0], VECS[v].exp);
            chk(obuf[0][31:24] == 8'hFF, "R3 alpha", 32'(obuf[0][31:24]), 32'hFF);
        end

        // R4 R7: background only, 3x2 raster flags
        clear_cfg();
        cfg_frame_w = 13'd3; cfg_frame_h = 13'd2; cfg_bg_rgb = 24'hA1B2C3;
        run_frame(6, 1'b0);
        for (int i = 0; i < 6; i++) begin
            chk(obuf[i] == 32'hFFA1B2C3, "R4 background", obuf[i], 32'hFFA1B2C3);
            chk(osof[i] == (i == 0), "R7 sof", 32'(osof[i]), 32'(i == 0));
            chk(oeol[i] == (i % 3 == 2), "R7 eol", 32'(oeol[i]), 32'(i % 3 == 2));
        end
        chk(out_valid == 1'b0, "R7 no extra pixel", 32'(out_valid), 0);

        // R5: layer 3 sits over layer 0
        clear_cfg();
        cfg_frame_w = 13'd1; cfg_frame_h = 13'd1; cfg_bg_rgb = 24'h000000;
        set_layer(0, 1'b1, 1'b0, 0, 0, 1, 1); lpix[0][0] = 32'hFFFF0000; lcnt[0] = 1;
        set_layer(3, 1'b1, 1'b0, 0, 0, 1, 1); lpix[3][0] = 32'h800000FF; lcnt[3] = 1;
        run_frame(1, 1'b0);
        chk(obuf[0] == 32'hFF7F0080, "R5 order", obuf[0], 32'hFF7F0080);

        // R6: disabled layer offering data is ignored
        clear_cfg();
        cfg_bg_rgb = 24'h000000;
        set_layer(0, 1'b1, 1'b0, 0, 0, 1, 1); lpix[0][0] = 32'hFF00FF00; lcnt[0] = 1;
        lyr_valid[1] = 1'b1; lyr_data[32 +: 32] = 32'hFFFFFFFF; dis_mask = 4'b0010;
        run_frame(1, 1'b0);
        chk(obuf[0] == 32'hFF00FF00, "R6 passthrough", obuf[0], 32'hFF00FF00);
        chk(saw_dis == 1'b0, "R6 ready held low", 32'(saw_dis), 0);
        lyr_valid[1] = 1'b0; dis_mask = '0;

        // R8 R9: clamped offsets, clipped pixels drained while others blend
        clear_cfg();
        cfg_frame_w = 13'd3; cfg_frame_h = 13'd2; cfg_bg_rgb = 24'h445566;
        set_layer(0, 1'b1, 1'b0, 5, 0, 2, 1);
        lpix[0][0] = 32'hFFAABBCC; lpix[0][1] = 32'hFF111111; lcnt[0] = 2;
        set_layer(1, 1'b1, 1'b0, 0, 9, 1, 2);
        lpix[1][0] = 32'hFF222222; lpix[1][1] = 32'hFF333333; lcnt[1] = 2;
        run_frame(6, 1'b0);
        chk(obuf[0] == 32'hFF445566, "R8 bg at (0,0)", obuf[0], 32'hFF445566);
        chk(obuf[1] == 32'hFF445566, "R8 bg at (1,0)", obuf[1], 32'hFF445566);
        chk(obuf[2] == 32'hFFAABBCC, "R8 x clamp", obuf[2], 32'hFFAABBCC);
        chk(obuf[3] == 32'hFF222222, "R8 y clamp", obuf[3], 32'hFF222222);
        chk(obuf[4] == 32'hFF445566, "R9 clipped not blended", obuf[4], 32'hFF445566);
        chk(obuf[5] == 32'hFF445566, "R9 clipped not blended", obuf[5], 32'hFF445566);
        chk(lyr_ready == '0, "R9 drained idle", 32'(lyr_ready), 0);

        // R7: size clamps
        clear_cfg();
        cfg_frame_w = 13'd0; cfg_frame_h = 13'd0;
        run_frame(1, 1'b0);
        chk(osof[0] && oeol[0], "R7 zero clamps to 1", 32'({osof[0], oeol[0]}), 32'h3);
        chk(out_valid == 1'b0, "R7 single pixel", 32'(out_valid), 0);
        cfg_frame_w = 13'd8191; cfg_frame_h = 13'd1;
        run_frame(8190, 1'b0);
        chk(eol_cnt == 1 && last_eol == 8189, "R7 width clamp eol", 32'(last_eol), 32'd8189);
        chk(sof_cnt == 1, "R7 width clamp sof", 32'(sof_cnt), 1);
        chk(out_valid == 1'b0, "R7 width clamp count", 32'(out_valid), 0);

        // R10: backpressure over distinct layer pixels
        clear_cfg();
        cfg_frame_w = 13'd4; cfg_frame_h = 13'd1;
        set_layer(0, 1'b1, 1'b0, 0, 0, 4, 1);
        for (int i = 0; i < 4; i++) lpix[0][i] = 32'hFF000001 + 32'(i);
        lcnt[0] = 4;
        run_frame(4, 1'b1);
        for (int i = 0; i < 4; i++)
            chk(obuf[i] == 32'hFF000001 + 32'(i), "R10 order under stall", obuf[i], 32'hFF000001 + 32'(i));
        chk(out_valid == 1'b0, "R10 no duplicate", 32'(out_valid), 0);

        // R11: mid-frame change applies next frame
        clear_cfg();
        cfg_frame_w = 13'd2; cfg_frame_h = 13'd2; cfg_bg_rgb = 24'h010203;
        chg_en = 1'b1; chg_val = 24'h0A0B0C;
        run_frame(4, 1'b0);
        chg_en = 1'b0;
        for (int i = 0; i < 4; i++)
            chk(obuf[i] == 32'hFF010203, "R11 frozen in frame", obuf[i], 32'hFF010203);
        run_frame(4, 1'b0);
        chk(obuf[0] == 32'hFF0A0B0C, "R11 next frame", obuf[0], 32'hFF0A0B0C);

        finish_run();
    end
endmodule